// File: doc/BRIEF.md
# Counter-Decoded Control Pulse Generator

This block runs a 4-bit binary counter and turns selected counts into three control enables. It produces one wide window and two single-cycle strobes, and the pattern repeats every 16 counted cycles. A downstream sequencer can use the enables as timing marks within each 16-state frame.

Each enable is a flip-flop loaded from the decode of the counter's *next* value. Because of this, an enable changes on the same clock edge as the count it belongs to, and it has no combinational glitches. A count enable input pauses the sequence. While it is paused, the enables keep the values decoded for the held count. A synchronous reset returns the counter to zero, and every enable is low at count zero.

Top module: `tick_pulse_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes 0 and `win_en`, `strobe_a` and `strobe_b` all become 0 after that edge. This holds whatever the value of `cnt_en`.
- R2: When `rst` is low and `cnt_en` is high at a rising edge, `count` increases by exactly one.
- R3: When `count` is 15 and the counter advances, the next value is 0. The enable pattern therefore repeats every 16 advances.
- R4: When `rst` is low and `cnt_en` is low at a rising edge, `count` and all three enables keep their values.
- R5: `win_en` is high exactly when `count` is 2, 3, 8, 9, 10 or 11.
- R6: `strobe_a` is high exactly when `count` is 5.
- R7: `strobe_b` is high exactly when `count` is 9. At that count `win_en` is high as well, so the two outputs overlap.
- R8: Every enable changes on the same clock edge as the `count` value it decodes. It never lags or leads the count by a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Advance the counter when high, hold it when low |
| count | output | 4 | Current counter state |
| win_en | output | 1 | Registered window enable (counts 2,3,8..11) |
| strobe_a | output | 1 | Registered strobe at count 5 |
| strobe_b | output | 1 | Registered strobe at count 9 |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges. They also assume that `cnt_en` and `rst` change only away from the rising edge, so every transition is taken from a clean registered value. The bench changes inputs only on the falling edge. It holds reset for several cycles at the start and asserts it again mid-sequence with `cnt_en` high. It sweeps more than two full wraps, with pauses placed at the enabled counts and at the wrap point, and compares each output against a decode computed arithmetically.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int CNT_W    = 4;
  localparam int NUM_ENS  = 3;
  localparam int STATES   = 1 << CNT_W;
  // Index 0: window (2,3,8..11), index 1: strobe at 5, index 2: strobe at 9
  localparam logic [NUM_ENS-1:0][STATES-1:0] DECODE_MASKS =
    {16'h0200, 16'h0020, 16'h0F0C};
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (rst)      nxt = '0;
    else if (adv) nxt = cur + W'(1);
    else          nxt = cur;
  end

  always_ff @(posedge clk) cur <= nxt;

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    adv |=> cur == W'($past(cur) + W'(1)));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && cur == {W{1'b1}}) |=> cur == '0);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cur));
endmodule

// File: rtl/tick_decoder.sv
module tick_decoder #(
  parameter int W = 4,
  parameter logic [(1<<W)-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt_state,
  output logic         hit_q
);
  logic hit_d;
  assign hit_d = MASK[nxt_state];

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_d;
  end
endmodule

// File: rtl/tick_pulse_gen.sv
module tick_pulse_gen
  import tick_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int N = NUM_ENS,
  parameter logic [N-1:0][(1<<W)-1:0] MASKS = DECODE_MASKS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  output logic [W-1:0] count,
  output logic         win_en,
  output logic         strobe_a,
  output logic         strobe_b
);
  logic [W-1:0] nxt;
  logic [N-1:0] ens;

  tick_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .adv(cnt_en), .cur(count), .nxt(nxt)
  );

  for (genvar g = 0; g < N; g++) begin : g_dec
    tick_decoder #(.W(W), .MASK(MASKS[g])) u_dec (
      .clk(clk), .rst(rst), .nxt_state(nxt), .hit_q(ens[g])
    );
  end

  assign win_en   = ens[0];
  assign strobe_a = ens[1];
  assign strobe_b = ens[2];

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !win_en && !strobe_a && !strobe_b));
  assert_hold_ens_R4: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(win_en) && $stable(strobe_a) && $stable(strobe_b)));
  assert_strobe_a_R6: assert property (@(posedge clk) disable iff (rst)
    strobe_a == (count == W'(5)));
  assert_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    (count == W'(9)) |-> (win_en && strobe_b));
  assert_strobe_b_R7: assert property (@(posedge clk) disable iff (rst)
    strobe_b |-> count == W'(9));
  assert_window_R5: assert property (@(posedge clk) disable iff (rst)
    win_en |-> (count[3:1] == 3'b001 || count[3:2] == 2'b10));
endmodule

// File: tb/test_tick_pulse_gen.sv
module test_tick_pulse_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic [3:0] count;
  logic win_en, strobe_a, strobe_b;
  int checks = 0;
  int fails = 0;
  int model = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_pulse_gen i_tick_pulse_gen (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .count(count),
    .win_en(win_en), .strobe_a(strobe_a), .strobe_b(strobe_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int w, a, b;
    w = ((model >= 2 && model <= 3) || (model >= 8 && model <= 11)) ? 1 : 0;
    a = (model == 5) ? 1 : 0;
    b = (model == 9) ? 1 : 0;
    chk({req, " count"}, int'(count), model);
    chk("R5 win_en", int'(win_en), w);
    chk("R6 strobe_a", int'(strobe_a), a);
    chk("R7 strobe_b", int'(strobe_b), b);
    if (model == 9) chk("R7 overlap", int'(win_en & strobe_b), 1);
  endtask

  // one clock with given inputs, then check the result (R8: same-edge alignment)
  task automatic step(input bit r, input bit e);
    @(negedge clk);
    rst = r; cnt_en = e;
    @(posedge clk);
    #2;
    if (r) model = 0;
    else if (e) model = (model + 1) % 16;
    if (r) check_all("R1");
    else if (!e) check_all("R4");
    else if (model == 0) check_all("R3");
    else check_all("R2 R8");
  endtask

  initial begin
    repeat (3) step(1'b1, 1'b0);
    step(1'b1, 1'b1);                        // R1: reset wins over cnt_en
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) begin       // pause at every count
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
    end
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);                        // R1: mid-run reset
    for (int i = 0; i < 20; i++) step(1'b0, ((i % 3) != 2));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule